// File: doc/BRIEF.md
# Inter-Phase Time Interval Meter

This block times the gap between two rising zero-crossing events of a three-phase system. The gap is counted in clock-enable ticks. Three channels run in parallel. Each channel has a start event and a stop event. When the stop event arrives, the channel copies its count into an unsigned result register. An upstream detector supplies the events as single-cycle pulses, one pulse for each negative-to-positive crossing of the voltage and of the current on phases A, B and C.

A 2-bit mode input chooses which pairs of events the three channels time:
- **Voltage to current (default):** each channel times its own phase, from the voltage crossing to the current crossing.
- **Voltage to voltage:** the channels time the delays between phase voltages.
- **Current to current:** the channels time the same phase pairs, using the current crossings.

If the mode changes, any measurement in progress is dropped. The previous results are kept.

Top module: `phase_delay_meter`

## Requirements
- R1: While `rst` is high, all three results go to zero and no channel is measuring. After reset, only a start event begins a measurement.
- R2: With mode 2'b00, channel k (0=A, 1=B, 2=C) starts on `zx_v[k]` and stops on `zx_i[k]`. Bit k of `zx_v` and of `zx_i` is the crossing event of phase k.
- R3: With mode 2'b01, the pairs are:
  - channel 0 starts on `zx_v[0]` and stops on `zx_v[1]`;
  - channel 1 starts on `zx_v[1]` and stops on `zx_v[2]`;
  - channel 2 starts on `zx_v[0]` and stops on `zx_v[2]`.
- R4: With mode 2'b10, the pairs are the same phase pairs as in R3, taken from `zx_i` instead of `zx_v`.
- R5: A result equals the number of cycles with `tick` high that fall strictly after the start cycle and strictly before the stop cycle. The result appears on the output in the cycle after the stop cycle.
- R6: A count that reaches 16'hFFFF stays there, and a later stop stores 16'hFFFF.
- R7: A start event during a measurement restarts that channel from zero. When a start and a stop arrive on the same channel in the same cycle, the start wins and the stop is ignored.
- R8: A stop event on a channel that is not measuring is ignored, and its result keeps its value.
- R9: In any cycle where `mode` differs from its value in the previous cycle, every measurement is aborted and that cycle's events are ignored. All results keep their values.
- R10: Mode 2'b11 selects the same pairs as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable for the counters; each high cycle is one count |
| mode | input | 2 | Selects the set of event pairs |
| zx_v | input | 3 | Rising voltage crossing pulses; bit 0 is phase A, bit 2 is phase C |
| zx_i | input | 3 | Rising current crossing pulses; bit 0 is phase A, bit 2 is phase C |
| res_a | output | 16 | Result of channel 0 |
| res_b | output | 16 | Result of channel 1 |
| res_c | output | 16 | Result of channel 2 |

## Verification
The bench times every channel in every mode. Swapping a pair in the event routing, or treating mode 2'b11 differently, would store a result in the wrong register, or no result at all.

Several corner cases are targeted directly:
- **Tick gaps and zero counts:** these expose a counter that counts clocks rather than ticks, or that includes the start or stop cycle.
- **A stop with no start before it:** this shows whether a stray stop overwrites a result.
- **A start and a stop in the same cycle:** this shows whether the start is given priority.
- **A mode switch mid-measurement:** a design that did not abort would store a stale count when the next stop arrives.
- **A run of more than 65535 ticks:** this catches a counter that wraps instead of saturating.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    SEL_VI  = 2'b00,
    SEL_VV  = 2'b01,
    SEL_II  = 2'b10,
    SEL_VI2 = 2'b11
  } sel_e;
endpackage

// File: rtl/zx_pair_route.sv
module zx_pair_route
  import pdm_pkg::*;
#(
  parameter int NPH = 3
) (
  input  sel_e           sel,
  input  logic [NPH-1:0] zv,
  input  logic [NPH-1:0] zi,
  output logic [NPH-1:0] start_o,
  output logic [NPH-1:0] stop_o
);
  // Inter-phase pairs: A->B, B->C, A->C
  logic [NPH-1:0] from_v, to_v, from_i, to_i;

  assign from_v = {zv[0], zv[1], zv[0]};
  assign to_v   = {zv[2], zv[2], zv[1]};
  assign from_i = {zi[0], zi[1], zi[0]};
  assign to_i   = {zi[2], zi[2], zi[1]};

  always_comb begin
    case (sel)
      SEL_VV: begin
        start_o = from_v;
        stop_o  = to_v;
      end
      SEL_II: begin
        start_o = from_i;
        stop_o  = to_i;
      end
      default: begin
        start_o = zv;
        stop_o  = zi;
      end
    endcase
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         abort,
  input  logic         start,
  input  logic         stop,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      res  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (stop && busy) begin
      res  <= cnt;
      busy <= 1'b0;
    end else if (busy && tick && (cnt != CMAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phase_delay_meter.sv
module phase_delay_meter
  import pdm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [2:0]   zx_v,
  input  logic [2:0]   zx_i,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic [W-1:0] res_c
);
  localparam int NPH = 3;

  sel_e           mode_q;
  logic           abort;
  logic [NPH-1:0] start_ev, stop_ev;
  logic [W-1:0]   res_arr [NPH];

  always_ff @(posedge clk) begin
    if (rst) mode_q <= SEL_VI;
    else     mode_q <= sel_e'(mode);
  end

  assign abort = (sel_e'(mode) != mode_q);

  zx_pair_route #(.NPH(NPH)) u_route (
    .sel     (sel_e'(mode)),
    .zv      (zx_v),
    .zi      (zx_i),
    .start_o (start_ev),
    .stop_o  (stop_ev)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ch
    interval_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .abort (abort),
      .start (start_ev[k]),
      .stop  (stop_ev[k]),
      .res   (res_arr[k])
    );
  end

  assign res_a = res_arr[0];
  assign res_b = res_arr[1];
  assign res_c = res_arr[2];
endmodule

// File: rtl/pdm_chk.sv
module pdm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic [1:0]   mode_q,
  input logic [2:0]   zx_v,
  input logic [2:0]   zx_i,
  input logic [2:0]   start_ev,
  input logic [2:0]   stop_ev,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b,
  input logic [W-1:0] res_c
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (res_a == '0 && res_b == '0 && res_c == '0));

  // R2
  default_pairs_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (start_ev == zx_v && stop_ev == zx_i));

  // R10
  alt_default_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> (start_ev == zx_v && stop_ev == zx_i));

  // R3
  volt_pairs_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (stop_ev == {zx_v[2], zx_v[2], zx_v[1]}));

  // R4
  curr_pairs_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (start_ev == {zx_i[0], zx_i[1], zx_i[0]}));

  // R9
  mode_switch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> ($stable(res_a) && $stable(res_b) && $stable(res_c)));

  // R8
  no_stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_ev[0] |=> $stable(res_a));
endmodule

bind phase_delay_meter pdm_chk #(.W(W)) u_pdm_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .mode_q   (mode_q),
  .zx_v     (zx_v),
  .zx_i     (zx_i),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .res_a    (res_a),
  .res_b    (res_b),
  .res_c    (res_c)
);

// File: tb/tb_phase_delay_meter.sv
module tb_phase_delay_meter;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic [1:0]  mode;
  logic [5:0]  ev;
  logic [15:0] res_a, res_b, res_c;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  phase_delay_meter dut (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .mode  (mode),
    .zx_v  (ev[2:0]),
    .zx_i  (ev[5:3]),
    .res_a (res_a),
    .res_b (res_b),
    .res_c (res_c)
  );

  // {mode[25:24], ch[23:22], start idx[21:19], stop idx[18:16], ticks[15:0]}
  // event idx 0..2 = voltage A..C, 3..5 = current A..C
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 2'd0, 3'd0, 3'd3, 16'd7},
    {2'b00, 2'd1, 3'd1, 3'd4, 16'd12},
    {2'b00, 2'd2, 3'd2, 3'd5, 16'd3},
    {2'b01, 2'd0, 3'd0, 3'd1, 16'd20},
    {2'b01, 2'd1, 3'd1, 3'd2, 16'd9},
    {2'b01, 2'd2, 3'd0, 3'd2, 16'd15},
    {2'b10, 2'd0, 3'd3, 3'd4, 16'd4},
    {2'b10, 2'd1, 3'd4, 3'd5, 16'd30},
    {2'b10, 2'd2, 3'd3, 3'd5, 16'd1},
    {2'b11, 2'd0, 3'd0, 3'd3, 16'd6},
    {2'b11, 2'd2, 3'd2, 3'd5, 16'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] m);
    ev   = m;
    tick = 1'b0;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic ticks(input int n, input bit alt);
    for (int i = 0; i < n; i++) begin
      tick = alt ? i[0] == 1'b0 : 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick(input logic [1:0] ch);
    return (ch == 2'd0) ? res_a : (ch == 2'd1) ? res_b : res_c;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; mode = 2'b00; ev = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", res_a, 16'h0);
    chk("R1", res_b, 16'h0);
    chk("R1", res_c, 16'h0);
    // R1 stop before any start stays ignored
    pulse(6'b001000);
    chk("R1", res_a, 16'h0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] vm;
      logic [1:0] vc;
      string      tag;
      vm = VEC[v][25:24];
      vc = VEC[v][23:22];
      if (vm != mode) set_mode(vm);
      pulse(6'b1 << VEC[v][21:19]);
      ticks(int'(VEC[v][15:0]), 1'b0);
      pulse(6'b1 << VEC[v][18:16]);
      case (vm)
        2'b00:   tag = "R2";
        2'b01:   tag = "R3";
        2'b10:   tag = "R4";
        default: tag = "R10";
      endcase
      chk(tag, pick(vc), VEC[v][15:0]);
    end

    set_mode(2'b00);
    // R5 only ticking cycles count (10 cycles, 5 with tick)
    pulse(6'b000001);
    ticks(10, 1'b1);
    pulse(6'b001000);
    chk("R5", res_a, 16'd5);

    // R7 restart on a second start
    pulse(6'b000001);
    ticks(5, 1'b0);
    pulse(6'b000001);
    ticks(3, 1'b0);
    pulse(6'b001000);
    chk("R7", res_a, 16'd3);

    // R7 start and stop in the same cycle: start wins
    pulse(6'b001001);
    chk("R7", res_a, 16'd3);
    ticks(2, 1'b0);
    pulse(6'b001000);
    chk("R7", res_a, 16'd2);

    // R8 stray stop while idle
    ticks(4, 1'b0);
    pulse(6'b001000);
    chk("R8", res_a, 16'd2);

    // R9 mode switch aborts a running measurement
    pulse(6'b000001);
    ticks(4, 1'b0);
    mode = 2'b11;
    ticks(3, 1'b0);
    pulse(6'b001000);
    chk("R9", res_a, 16'd2);

    // R6 saturation
    pulse(6'b000010);
    ticks(70000, 1'b0);
    pulse(6'b010000);
    chk("R6", res_b, 16'hFFFF);

    // R1 reset clears results mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", res_b, 16'h0);
    chk("R1", res_a, 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule